// File: doc/BRIEF.md
# Trap Return and Privilege Gate

This block sits beside the instruction decoder of a core that implements user, supervisor and machine privilege levels. It holds the current privilege level, the saved exception PCs of supervisor and machine mode, and the status fields that govern returning from a trap. It executes four system instructions: supervisor return, machine return, wait-for-interrupt and the address-translation fence.

A return that passes every check produces a one-cycle result carrying the saved PC, which the fetch unit uses as the redirect target. The same clock edge restores privilege and the interrupt enables. A failing check produces a one-cycle exception result with a cause code and leaves all state untouched. Wait-for-interrupt raises a halt level that holds until an interrupt is pending. The fence produces a one-cycle flush pulse for the translation caches.

Two configuration inputs shape the checks. One says whether compressed instructions are supported, which relaxes target alignment. The other selects the current privileged-architecture rules or the legacy ones. Under legacy rules the trap-virtualization bits are ignored, and a return restores the enable bit picked by the previous privilege level. Trap entry writes the state through a load port.

Top module: `trapret_gate`

## Requirements
- R1: After reset, privilege is machine (2'b11), all status bits are 0, both saved PCs are 0, and ret_valid, exc_valid, flush and halt are 0.
- R2: A load writes privilege, status and both saved PCs, visible one cycle later. A privilege value or machine previous-privilege value of 2'b10 is stored as 2'b00. An operation presented in the same cycle as a load has no effect and produces no result. Status bit layout: [0] user enable, [1] supervisor enable, [2] machine enable, [3] supervisor previous enable, [4] machine previous enable, [5] supervisor previous privilege, [7:6] machine previous privilege, [8] trap-supervisor-return, [9] timeout-wait, [10] trap-translation.
- R3: op_code 0 (supervisor return) in user mode, or op_code 1 (machine return) below machine mode, gives exc_valid with exc_code 2 (illegal).
- R4: A successful return gives ret_valid for one cycle, with ret_pc equal to the saved supervisor PC (op 0) or machine PC (op 1).
- R5: Without compressed support, a return whose target has non-zero low two bits gives exc_code 0 (misaligned). This check comes after the privilege check and before the trap-supervisor-return check. With compressed support the target is not checked.
- R6: Under current rules, a supervisor return with status[8] set gives exc_code 2. Under legacy rules status[8] has no effect.
- R7: A successful return under current rules sets privilege to the previous-privilege field and copies the previous-enable bit into that mode's enable bit (supervisor [1] or machine [2]). It then clears the previous-enable bit and sets the previous-privilege field to user.
- R8: Under legacy rules the restored enable bit is selected by the previous privilege: user sets [0], supervisor sets [1], machine sets [2].
- R9: Wait-for-interrupt (op 2) in supervisor mode with status[9] set under current rules gives exc_code 2. Otherwise halt rises one cycle later and stays high until a cycle in which irq_pending is high. irq_pending in the same cycle as the instruction keeps halt low.
- R10: The fence (op 3) in supervisor mode with status[10] set under current rules gives exc_code 2. Otherwise flush is high for exactly one cycle.
- R11: An exception leaves privilege and status unchanged.
- R12: At most one of ret_valid, exc_valid and flush is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load state from trap entry |
| ld_priv | input | 2 | Privilege to load |
| ld_status | input | 11 | Status to load |
| ld_sepc | input | XLEN | Supervisor saved PC to load |
| ld_mepc | input | XLEN | Machine saved PC to load |
| op_valid | input | 1 | Instruction present |
| op_code | input | 2 | 0 sup return, 1 mach return, 2 wait, 3 fence |
| has_compressed | input | 1 | Compressed instructions supported |
| new_spec | input | 1 | Current (1) or legacy (0) rules |
| irq_pending | input | 1 | Interrupt pending, ends halt |
| ret_valid | output | 1 | Return taken |
| ret_pc | output | XLEN | Return target |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 4 | 2 illegal, 0 misaligned |
| flush | output | 1 | Translation flush pulse |
| halt | output | 1 | Halt request |
| priv_o | output | 2 | Current privilege |
| status_o | output | 11 | Current status |

## Verification
Every result is registered. An instruction sampled at one rising edge shows its ret_valid, exc_valid, flush, new privilege, new status and halt change right after that edge. A load shows its state after the edge that samples it as well. The bench drives inputs on the falling edge and advances a behavioural model by one step at that moment. At the next falling edge it compares every output with the model, so each result is checked exactly one edge after its stimulus. The bench also checks that a halt persists over idle cycles and that the flush pulse ends after one cycle.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] OP_SRET  = 2'd0;
  localparam logic [1:0] OP_MRET  = 2'd1;
  localparam logic [1:0] OP_WFI   = 2'd2;
  localparam logic [1:0] OP_FENCE = 2'd3;

  localparam logic [3:0] EXC_MISALIGN = 4'd0;
  localparam logic [3:0] EXC_ILLEGAL  = 4'd2;

  typedef struct packed {
    logic       tvm;
    logic       tw;
    logic       tsr;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
    logic       uie;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

  // A privilege value with no mode behind it is held as user.
  function automatic logic [1:0] fn_legal_priv(input logic [1:0] v);
    return (v == 2'b10) ? PRIV_U : v;
  endfunction

  function automatic logic fn_misaligned(input logic [1:0] low, input logic has_c);
    return !has_c && (low != 2'b00);
  endfunction

  function automatic logic [1:0] fn_ret_priv(input stat_t s, input logic is_m);
    return is_m ? s.mpp : {1'b0, s.spp};
  endfunction

  function automatic stat_t fn_ret_status(input stat_t s, input logic is_m,
                                          input logic new_spec);
    stat_t      r;
    logic       pie;
    logic [1:0] pp;
    r   = s;
    pie = is_m ? s.mpie : s.spie;
    pp  = fn_ret_priv(s, is_m);
    if (new_spec) begin
      if (is_m) r.mie = pie;
      else      r.sie = pie;
    end else begin
      case (pp)
        PRIV_U:  r.uie = pie;
        PRIV_S:  r.sie = pie;
        PRIV_M:  r.mie = pie;
        default: r.uie = s.uie;
      endcase
    end
    if (is_m) begin
      r.mpie = 1'b0;
      r.mpp  = PRIV_U;
    end else begin
      r.spie = 1'b0;
      r.spp  = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/trapret_check.sv
module trapret_check
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            fire,
  input  logic [1:0]      code,
  input  logic [1:0]      priv,
  input  logic            tsr,
  input  logic            tw,
  input  logic            tvm,
  input  logic [XLEN-1:0] sepc,
  input  logic [XLEN-1:0] mepc,
  input  logic            has_c,
  input  logic            new_spec,
  output logic            go_ret,
  output logic            go_wfi,
  output logic            go_fence,
  output logic            go_exc,
  output logic [3:0]      exc_kind,
  output logic [XLEN-1:0] tgt_pc,
  output logic            ret_is_m
);

  logic tgt_mis;

  assign ret_is_m = (code == OP_MRET);
  assign tgt_pc   = ret_is_m ? mepc : sepc;
  assign tgt_mis  = fn_misaligned(tgt_pc[1:0], has_c);

  // Checks run in a fixed order: privilege, alignment, trap bits.
  always_comb begin
    go_ret   = 1'b0;
    go_wfi   = 1'b0;
    go_fence = 1'b0;
    go_exc   = 1'b0;
    exc_kind = EXC_ILLEGAL;
    if (fire) begin
      case (code)
        OP_SRET: begin
          if (priv == PRIV_U) go_exc = 1'b1;
          else if (tgt_mis) begin
            go_exc   = 1'b1;
            exc_kind = EXC_MISALIGN;
          end else if (new_spec && tsr) go_exc = 1'b1;
          else go_ret = 1'b1;
        end
        OP_MRET: begin
          if (priv != PRIV_M) go_exc = 1'b1;
          else if (tgt_mis) begin
            go_exc   = 1'b1;
            exc_kind = EXC_MISALIGN;
          end else go_ret = 1'b1;
        end
        OP_WFI: begin
          if (priv == PRIV_S && new_spec && tw) go_exc = 1'b1;
          else go_wfi = 1'b1;
        end
        default: begin
          if (priv == PRIV_S && new_spec && tvm) go_exc = 1'b1;
          else go_fence = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/trapret_update.sv
module trapret_update
  import trapret_pkg::*;
(
  input  logic       ld_valid,
  input  logic [1:0] ld_priv,
  input  stat_t      ld_st,
  input  logic [1:0] priv,
  input  stat_t      st,
  input  logic       go_ret,
  input  logic       ret_is_m,
  input  logic       new_spec,
  output logic [1:0] priv_nxt,
  output stat_t      st_nxt
);

  always_comb begin
    priv_nxt = priv;
    st_nxt   = st;
    if (ld_valid) begin
      priv_nxt   = fn_legal_priv(ld_priv);
      st_nxt     = ld_st;
      st_nxt.mpp = fn_legal_priv(ld_st.mpp);
    end else if (go_ret) begin
      priv_nxt = fn_ret_priv(st, ret_is_m);
      st_nxt   = fn_ret_status(st, ret_is_m, new_spec);
    end
  end

endmodule

// File: rtl/trapret_halt.sv
module trapret_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic irq,
  output logic halt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt <= 1'b0;
    else        halt <= (halt | set_req) & ~irq;
  end

  AST_IRQ_ENDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !halt); // R9

  AST_WAIT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !irq) |=> halt); // R9

endmodule

// File: rtl/trapret_gate.sv
module trapret_gate
  import trapret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [1:0]        ld_priv,
  input  logic [STAT_W-1:0] ld_status,
  input  logic [XLEN-1:0]   ld_sepc,
  input  logic [XLEN-1:0]   ld_mepc,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              has_compressed,
  input  logic              new_spec,
  input  logic              irq_pending,
  output logic              ret_valid,
  output logic [XLEN-1:0]   ret_pc,
  output logic              exc_valid,
  output logic [3:0]        exc_code,
  output logic              flush,
  output logic              halt,
  output logic [1:0]        priv_o,
  output logic [STAT_W-1:0] status_o
);

  logic [1:0]      priv_q, priv_nxt;
  stat_t           st_q, st_nxt;
  logic [XLEN-1:0] sepc_q, mepc_q;
  logic            op_fire;
  logic            go_ret, go_wfi, go_fence, go_exc, ret_is_m;
  logic [3:0]      exc_kind;
  logic [XLEN-1:0] tgt_pc;
  logic            ret_was_m_q;

  assign op_fire = op_valid & ~ld_valid;

  trapret_check #(.XLEN(XLEN)) check_i (
    .fire     (op_fire),
    .code     (op_code),
    .priv     (priv_q),
    .tsr      (st_q.tsr),
    .tw       (st_q.tw),
    .tvm      (st_q.tvm),
    .sepc     (sepc_q),
    .mepc     (mepc_q),
    .has_c    (has_compressed),
    .new_spec (new_spec),
    .go_ret   (go_ret),
    .go_wfi   (go_wfi),
    .go_fence (go_fence),
    .go_exc   (go_exc),
    .exc_kind (exc_kind),
    .tgt_pc   (tgt_pc),
    .ret_is_m (ret_is_m)
  );

  trapret_update update_i (
    .ld_valid (ld_valid),
    .ld_priv  (ld_priv),
    .ld_st    (stat_t'(ld_status)),
    .priv     (priv_q),
    .st       (st_q),
    .go_ret   (go_ret),
    .ret_is_m (ret_is_m),
    .new_spec (new_spec),
    .priv_nxt (priv_nxt),
    .st_nxt   (st_nxt)
  );

  trapret_halt halt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (go_wfi),
    .irq     (irq_pending),
    .halt    (halt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q      <= PRIV_M;
      st_q        <= '0;
      sepc_q      <= '0;
      mepc_q      <= '0;
      ret_valid   <= 1'b0;
      ret_pc      <= '0;
      exc_valid   <= 1'b0;
      exc_code    <= EXC_MISALIGN;
      flush       <= 1'b0;
      ret_was_m_q <= 1'b0;
    end else begin
      priv_q    <= priv_nxt;
      st_q      <= st_nxt;
      ret_valid <= go_ret;
      exc_valid <= go_exc;
      flush     <= go_fence;
      if (ld_valid) begin
        sepc_q <= ld_sepc;
        mepc_q <= ld_mepc;
      end
      if (go_ret) begin
        ret_pc      <= tgt_pc;
        ret_was_m_q <= ret_is_m;
      end
      if (go_exc) exc_code <= exc_kind;
    end
  end

  assign priv_o   = priv_q;
  assign status_o = st_q;

  AST_EXC_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (priv_o == $past(priv_o)) && (status_o == $past(status_o))); // R11

  AST_SRET_FROM_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && op_code == OP_SRET && priv_o == PRIV_U)
      |=> exc_valid && exc_code == EXC_ILLEGAL); // R3

  AST_MRET_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && op_code == OP_MRET && priv_o != PRIV_M)
      |=> exc_valid && exc_code == EXC_ILLEGAL); // R3

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_valid, exc_valid, flush})); // R12

  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !$past(has_compressed)) |-> ret_pc[1:0] == 2'b00); // R5

  AST_PREV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_was_m_q ? (!st_q.mpie && st_q.mpp == PRIV_U)
                               : (!st_q.spie && !st_q.spp))); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ret_valid && !exc_valid && !flush); // R2

endmodule

// File: tb/trapret_gate_tb_top.sv
`timescale 1ns/1ps
module trapret_gate_tb_top;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_valid = 1'b0;
  logic [1:0]      ld_priv = '0;
  logic [10:0]     ld_status = '0;
  logic [XLEN-1:0] ld_sepc = '0;
  logic [XLEN-1:0] ld_mepc = '0;
  logic            op_valid = 1'b0;
  logic [1:0]      op_code = '0;
  logic            has_compressed = 1'b0;
  logic            new_spec = 1'b1;
  logic            irq_pending = 1'b0;
  logic            ret_valid, exc_valid, flush, halt;
  logic [XLEN-1:0] ret_pc;
  logic [3:0]      exc_code;
  logic [1:0]      priv_o;
  logic [10:0]     status_o;

  always #2.5 clk = ~clk;

  trapret_gate #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_priv(ld_priv),
    .ld_status(ld_status), .ld_sepc(ld_sepc), .ld_mepc(ld_mepc),
    .op_valid(op_valid), .op_code(op_code), .has_compressed(has_compressed),
    .new_spec(new_spec), .irq_pending(irq_pending), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .exc_valid(exc_valid), .exc_code(exc_code),
    .flush(flush), .halt(halt), .priv_o(priv_o), .status_o(status_o)
  );

  int total = 0;
  int bad = 0;

  // reference model state
  int       m_priv = 3;
  bit [10:0] m_st = '0;
  int unsigned m_sepc = 0, m_mepc = 0;
  bit       m_ret = 0, m_exc = 0, m_flush = 0, m_halt = 0;
  int unsigned m_pc = 0;
  int       m_code = 0;

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "ret_valid", ret_valid, m_ret);
    if (m_ret) check(tag, "ret_pc", ret_pc, m_pc);
    check(tag, "exc_valid", exc_valid, m_exc);
    if (m_exc) check(tag, "exc_code", exc_code, m_code);
    check(tag, "flush", flush, m_flush);
    check(tag, "halt", halt, m_halt);
    check(tag, "priv", priv_o, m_priv);
    check(tag, "status", status_o, m_st);
  endtask

  function automatic void raise(input int c);
    m_exc = 1;
    m_code = c;
  endfunction

  function automatic void model_step();
    bit wait_ok = 0;
    int pp;
    bit pie;
    bit is_m;
    m_ret = 0; m_exc = 0; m_flush = 0;
    if (ld_valid) begin
      m_priv = (ld_priv == 2) ? 0 : int'(ld_priv);
      m_st = ld_status;
      if (m_st[7:6] == 2'b10) m_st[7:6] = 2'b00;
      m_sepc = ld_sepc;
      m_mepc = ld_mepc;
    end else if (op_valid) begin
      if (op_code <= 1) begin
        is_m = (op_code == 1);
        m_pc = is_m ? m_mepc : m_sepc;
        if ((is_m && m_priv != 3) || (!is_m && m_priv == 0)) raise(2);
        else if (!has_compressed && (m_pc % 4) != 0) raise(0);
        else if (!is_m && new_spec && m_st[8]) raise(2);
        else begin
          m_ret = 1;
          pp  = is_m ? int'(m_st[7:6]) : int'(m_st[5]);
          pie = is_m ? m_st[4] : m_st[3];
          if (new_spec) m_st[is_m ? 2 : 1] = pie;
          else if (pp == 0) m_st[0] = pie;
          else if (pp == 1) m_st[1] = pie;
          else m_st[2] = pie;
          if (is_m) begin m_st[4] = 0; m_st[7:6] = 0; end
          else begin m_st[3] = 0; m_st[5] = 0; end
          m_priv = pp;
        end
      end else if (op_code == 2) begin
        if (m_priv == 1 && new_spec && m_st[9]) raise(2);
        else wait_ok = 1;
      end else begin
        if (m_priv == 1 && new_spec && m_st[10]) raise(2);
        else m_flush = 1;
      end
    end
    m_halt = (m_halt || wait_ok) && !irq_pending;
  endfunction

  // inputs are set at a falling edge; results compared at the next one
  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    compare_all(tag);
    ld_valid = 0;
    op_valid = 0;
    irq_pending = 0;
  endtask

  task automatic load(input int p, input bit [10:0] s, input int unsigned se,
                      input int unsigned me, input string tag);
    ld_valid = 1; ld_priv = p[1:0]; ld_status = s; ld_sepc = se; ld_mepc = me;
    tick(tag);
  endtask

  task automatic op(input int c, input string tag);
    op_valid = 1; op_code = c[1:0];
    tick(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    // R4 R7: machine return into supervisor, mpie=1 mpp=S
    load(3, 11'b000_01_0_1_0_0_0_0, 32'h200, 32'h100, "R2");
    op(1, "R4_R7");
    // R7: supervisor return into user, spie=1 spp=0
    load(1, 11'b000_00_0_0_1_0_0_0, 32'h300, 32'h0, "R2");
    op(0, "R7");
    // R3: supervisor return in user; R11 state held
    op(0, "R3_R11");
    load(1, 11'b000_11_1_1_1_0_0_0, 32'h40, 32'h50, "R2");
    op(1, "R3_R11");

    // R5: misaligned machine target, then compressed allowed
    has_compressed = 0;
    load(3, 11'b000_01_0_1_0_0_0_0, 32'h0, 32'h102, "R2");
    op(1, "R5");
    has_compressed = 1;
    op(1, "R5");
    has_compressed = 0;
    // R5 ordering: misaligned beats trap-supervisor-return
    load(1, 11'b001_00_0_0_1_0_0_0, 32'h206, 32'h0, "R2");
    op(0, "R5");

    // R6: trap-supervisor-return under current and legacy rules
    load(1, 11'b001_00_1_0_1_0_0_0, 32'h208, 32'h0, "R2");
    op(0, "R6");
    new_spec = 0;
    op(0, "R6_R8");

    // R8: legacy machine return with mpp=U restores user enable
    load(3, 11'b000_00_0_1_0_0_0_0, 32'h0, 32'h400, "R2");
    op(1, "R8");
    load(3, 11'b000_11_0_1_0_0_0_0, 32'h0, 32'h404, "R2");
    op(1, "R8");
    new_spec = 1;

    // R9: wait gated, then halt and release
    load(1, 11'b010_00_0_0_0_0_0_0, 32'h0, 32'h0, "R2");
    op(2, "R9");
    new_spec = 0;
    op(2, "R9");
    tick("R9");
    tick("R9");
    irq_pending = 1;
    tick("R9");
    tick("R9");
    new_spec = 1;
    op_valid = 1; op_code = 2; irq_pending = 1;
    tick("R9");
    load(3, 11'b010_00_0_0_0_0_0_0, 32'h0, 32'h0, "R2");
    op(2, "R9");
    irq_pending = 1;
    tick("R9");

    // R10: fence gated in supervisor, allowed in user
    load(1, 11'b100_00_0_0_0_0_0_0, 32'h0, 32'h0, "R2");
    op(3, "R10");
    load(0, 11'b100_00_0_0_0_0_0_0, 32'h0, 32'h0, "R2");
    op(3, "R10_R12");
    tick("R10");

    // R2: reserved encodings and load priority over an operation
    load(2, 11'b000_10_0_0_0_0_0_0, 32'h0, 32'h0, "R2");
    op_valid = 1; op_code = 3;
    load(3, 11'b000_01_0_1_0_0_0_0, 32'h0, 32'h80, "R2");
    tick("R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule